// File: doc/BRIEF.md
# Selectable Fractional Clock-Enable Divider

This block turns one of several incoming clock-enable pulse streams into a slower pulse stream, at a rate set by a fixed-point ratio. A source-select field picks the stream. A first-order phase accumulator spreads the output pulses evenly, so that a ratio such as 2.5 gives two output pulses for every five selected input pulses. The output is a single-cycle enable, `clk_en_out`, meant to qualify logic in the system clock domain. No clock is gated.

Software-facing state is kept in two registers, and both are written through plain strobes. The control register holds the enable bit and the source field. Its busy flag always equals the enable bit. The divider register is a 32-bit word in which the ratio sits at a fixed anchor. Two parameters set the widths of the integer and fractional parts. When both widths are zero, the block passes the selected stream through without dividing it.

No data stream crosses the block's edge, so there is no valid/ready handshake. Every pin is a plain control or status signal, sampled on the rising edge of `clk`.

Top module: `cfdm_top`

## Requirements
- R1: One cycle after a control write, `busy` equals the enable bit that was written. `busy` is 0 after reset.
- R2: While the enable bit is clear, `clk_en_out` stays 0 whatever arrives on `src_pulse`.
- R3: The integer part of the divider is read from `div_word` starting at bit 12 and going upward for INT_BITS bits. The fractional part is the FRAC_BITS bits just below bit 12. All other bits of the word are ignored. `cur_div` shows the combined value {integer, fraction}.
- R4: A combined divider value of zero holds `clk_en_out` at 0.
- R5: Each selected source pulse adds 2^FRAC_BITS to a phase accumulator. When the sum reaches the divider value, one output pulse is produced and the divider value is subtracted. The result is an average output rate equal to the input rate times 2^FRAC_BITS divided by the divider. Each output pulse appears in the cycle after the edge that sampled its source pulse.
- R6: Source index 0 is ground and never yields a pulse, even when `src_pulse[0]` is high. An index of NUM_SRC or above also acts as ground. Index k (1 to NUM_SRC-1) selects `src_pulse[k]`.
- R7: Any control or divider write clears the accumulator. The source pulse sampled in the cycle of that write yields no output.
- R8: A nonzero divider of at most 2^FRAC_BITS (a ratio of 1 or less) passes every selected pulse, and the accumulator is held at zero.
- R9: When INT_BITS and FRAC_BITS are both zero, every selected pulse passes through with the same one-cycle latency, subject to R2, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Enable bit written by `ctl_we` |
| ctl_src | input | SW | Source index written by `ctl_we` |
| div_we | input | 1 | Divider register write strobe |
| div_word | input | 32 | Divider register word; ratio anchored at bit 12 |
| src_pulse | input | NUM_SRC | Incoming clock-enable pulses, one per source |
| busy | output | 1 | Mirrors the stored enable bit |
| cur_src | output | SW | Stored source index |
| cur_div | output | max(DW,1) | Stored combined divider {integer, fraction} |
| clk_en_out | output | 1 | Divided output enable pulse |

## Verification
The hardest case to reach from the ports is a write that lands while the accumulator holds a residue large enough for the next pulse to emit. An RTL that skipped the clear would show the fault only one pulse later. The bench drives two pulses at a ratio of 2.5 to build a residue of 32 out of 40. It then rewrites the same divider value, so the only observable effect is the clear. It then checks that the following pulse stays silent. Ratios at or below one are also exercised, because they are where an unclamped accumulator would grow without bound.

// File: rtl/cfdm_pkg.sv
package cfdm_pkg;
  localparam int unsigned DIV_ANCHOR = 12;
  localparam int unsigned REG_W      = 32;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfdm_ctl_regs.sv
module cfdm_ctl_regs
  import cfdm_pkg::*;
#(
  parameter int unsigned SW        = 4,
  parameter int unsigned INT_BITS  = 8,
  parameter int unsigned FRAC_BITS = 4,
  localparam int unsigned DW  = INT_BITS + FRAC_BITS,
  localparam int unsigned DWP = (DW > 0) ? DW : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_enable,
  input  logic [SW-1:0]    ctl_src,
  input  logic             div_we,
  input  logic [REG_W-1:0] div_word,
  output logic             en_q,
  output logic [SW-1:0]    src_q,
  output logic [DWP-1:0]   div_q,
  output logic             any_wr
);
  logic [DWP-1:0] div_field;

  generate
    if (DW > 0) begin : g_field
      assign div_field = div_word[DIV_ANCHOR+INT_BITS-1 -: DWP];
    end else begin : g_nofield
      assign div_field = '0;
    end
  endgenerate

  assign any_wr = ctl_we | div_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      src_q <= '0;
    end else if (ctl_we) begin
      en_q  <= ctl_enable;
      src_q <= ctl_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_we) div_q <= div_field;
  end

  AST_BUSY_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (en_q == $past(ctl_enable))); // R1
endmodule

// File: rtl/cfdm_src_pick.sv
module cfdm_src_pick #(
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned SW      = 4
) (
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [SW-1:0]      sel,
  output logic               picked
);
  always_comb begin
    picked = 1'b0;
    for (int k = 1; k < NUM_SRC; k++) begin
      if (sel == SW'(k)) picked = src_pulse[k];
    end
  end
endmodule

// File: rtl/cfdm_frac_acc.sv
module cfdm_frac_acc #(
  parameter int unsigned DW        = 12,
  parameter int unsigned FRAC_BITS = 4,
  localparam int unsigned AW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          pulse,
  input  logic [DW-1:0] div,
  output logic          out_q
);
  localparam logic [AW-1:0] ONE = AW'(1) << FRAC_BITS;

  logic [AW-1:0] acc_q, acc_d, sum, div_ext;
  logic          hit;

  assign div_ext = {1'b0, div};
  assign sum     = acc_q + ONE;

  always_comb begin
    hit   = 1'b0;
    acc_d = acc_q;
    if (clr || !en || (div == '0)) begin
      acc_d = '0;
    end else if (pulse) begin
      if (div_ext <= ONE) begin
        hit   = 1'b1;
        acc_d = '0;
      end else if (sum >= div_ext) begin
        hit   = 1'b1;
        acc_d = sum - div_ext;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      out_q <= hit;
    end
  end

  AST_ZERO_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !out_q); // R4
  AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0) || (acc_q < div_ext)); // R5
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((acc_q == '0) && !out_q)); // R7
endmodule

// File: rtl/cfdm_top.sv
module cfdm_top
  import cfdm_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 10,
  parameter int unsigned INT_BITS  = 8,
  parameter int unsigned FRAC_BITS = 4,
  localparam int unsigned SW  = sel_width(NUM_SRC),
  localparam int unsigned DW  = INT_BITS + FRAC_BITS,
  localparam int unsigned DWP = (DW > 0) ? DW : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               ctl_enable,
  input  logic [SW-1:0]      ctl_src,
  input  logic               div_we,
  input  logic [REG_W-1:0]   div_word,
  input  logic [NUM_SRC-1:0] src_pulse,
  output logic               busy,
  output logic [SW-1:0]      cur_src,
  output logic [DWP-1:0]     cur_div,
  output logic               clk_en_out
);
  logic en_q, any_wr, picked;

  cfdm_ctl_regs #(.SW(SW), .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_src(ctl_src), .div_we(div_we), .div_word(div_word),
    .en_q(en_q), .src_q(cur_src), .div_q(cur_div), .any_wr(any_wr)
  );

  cfdm_src_pick #(.NUM_SRC(NUM_SRC), .SW(SW)) u_pick (
    .src_pulse(src_pulse), .sel(cur_src), .picked(picked)
  );

  generate
    if (DW > 0) begin : g_divide
      cfdm_frac_acc #(.DW(DW), .FRAC_BITS(FRAC_BITS)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(any_wr), .en(en_q),
        .pulse(picked), .div(cur_div), .out_q(clk_en_out)
      );
    end else begin : g_pass
      logic pass_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= en_q & picked & ~any_wr;
      end
      assign clk_en_out = pass_q;
    end
  endgenerate

  assign busy = en_q;

  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !clk_en_out); // R2
  AST_GROUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src == '0) |=> !clk_en_out); // R6
endmodule

// File: tb/sim_cfdm_top.sv
module sim_cfdm_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_enable = 1'b0, div_we = 1'b0;
  logic [3:0]  ctl_src = '0;
  logic [31:0] div_word = '0;
  logic [NSRC-1:0] src_pulse = '0;
  logic        busy, out0;
  logic [3:0]  cur_src;
  logic [11:0] cur_div;
  logic        busy1, out1;
  logic [1:0]  cur_src1;
  logic [0:0]  cur_div1;

  int checks = 0, errors = 0, cyc = 0, outcnt = 0;
  bit done = 0;
  bit   q0[$], q1[$];
  string t0[$];

  int m_en = 0, m_src = 0, m_div = 0, m_acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfdm_top #(.NUM_SRC(NSRC), .INT_BITS(8), .FRAC_BITS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_src(ctl_src), .div_we(div_we), .div_word(div_word),
    .src_pulse(src_pulse), .busy(busy), .cur_src(cur_src),
    .cur_div(cur_div), .clk_en_out(out0)
  );

  cfdm_top #(.NUM_SRC(4), .INT_BITS(0), .FRAC_BITS(0)) u1 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_src(ctl_src[1:0]), .div_we(div_we), .div_word(div_word),
    .src_pulse(src_pulse[3:0]), .busy(busy1), .cur_src(cur_src1),
    .cur_div(cur_div1), .clk_en_out(out1)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, model pushes expected outputs.
  task automatic step(input bit cw, input bit ce, input int cs,
                      input bit dw, input logic [31:0] dword,
                      input logic [NSRC-1:0] p, input string tag);
    bit e0, e1;
    @(negedge clk);
    ctl_we = cw; ctl_enable = ce; ctl_src = 4'(cs);
    div_we = dw; div_word = dword; src_pulse = p;
    e0 = 0; e1 = 0;
    if (cw || dw) begin
      m_acc = 0;                                   // R7
      if (cw) begin m_en = ce; m_src = cs; end
      if (dw) m_div = (dword >> 8) & 32'hFFF;      // R3
    end else begin
      e1 = (m_en != 0) && (m_src & 3) != 0 && (m_src < 4) && p[m_src & 3]; // R9
      if (m_en == 0 || m_div == 0) m_acc = 0;      // R2 R4
      else if (m_src != 0 && m_src < NSRC && p[m_src]) begin // R6
        if (m_div <= 16) begin e0 = 1; m_acc = 0; end        // R8
        else if (m_acc + 16 >= m_div) begin e0 = 1; m_acc = m_acc + 16 - m_div; end // R5
        else m_acc = m_acc + 16;
      end
    end
    q0.push_back(e0); t0.push_back(tag); q1.push_back(e1);
  endtask

  task automatic idle(input logic [NSRC-1:0] p, input string tag);
    step(0, 0, 0, 0, 32'h0, p, tag);
  endtask

  task automatic wctl(input bit e, input int s);
    step(1, e, s, 0, 32'h0, '1, "R7");
  endtask

  task automatic wdiv(input logic [31:0] w);
    step(0, 0, 0, 1, w, '1, "R7");
  endtask

  task automatic drain();
    @(negedge clk);
    ctl_we = 0; div_we = 0; src_pulse = '0;
    @(negedge clk);
  endtask

  // Monitor: pops expectations after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q0.size() > 0) begin
        bit e; string tg;
        e = q0.pop_front(); tg = t0.pop_front();
        check(tg, int'(out0), int'(e));
        if (out0) outcnt++;
      end
      if (q1.size() > 0) begin
        bit e;
        e = q1.pop_front();
        check("R9 passthrough", int'(out1), int'(e));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R2 reset out", int'(out0), 0);
    check("R3 reset div", int'(cur_div), 0);
    rst_n = 1'b1;

    // Ratio 2.5 with junk outside the field.
    wdiv(32'hFFF0_00FF | 32'h0000_2800);
    drain();
    check("R3 field extract", int'(cur_div), 40);
    wctl(1, 1);
    drain();
    check("R1 busy after enable", int'(busy), 1);
    outcnt = 0;
    for (int i = 0; i < 20; i++) idle(10'b0000000010, "R5 ratio 2.5");
    drain();
    check("R5 count 2/5", outcnt, 8);

    outcnt = 0;
    for (int i = 0; i < 20; i++) idle((i % 2) ? 10'b0000000010 : 10'b0, "R5 sparse");
    drain();
    check("R5 sparse count", outcnt, 4);

    // Write clears residue: acc 32 then same divider rewritten.
    wdiv(32'h0000_2800);
    idle(10'b10, "R7 build"); idle(10'b10, "R7 build");
    wdiv(32'h0000_2800);
    idle(10'b10, "R7 after clear");
    idle(10'b10, "R7 after clear"); idle(10'b10, "R7 after clear");

    wdiv(32'h0);
    for (int i = 0; i < 6; i++) idle('1, "R4 zero divider");

    wdiv(32'h0000_1000);
    for (int i = 0; i < 5; i++) idle(10'b10, "R8 ratio one");
    wdiv(32'h0000_0800);
    for (int i = 0; i < 5; i++) idle(10'b10, "R8 ratio half");

    wctl(1, 0);
    for (int i = 0; i < 4; i++) idle(10'b1, "R6 ground");
    wctl(1, 12);
    for (int i = 0; i < 4; i++) idle('1, "R6 out of range");
    wdiv(32'h0000_3000);
    wctl(1, 5);
    for (int i = 0; i < 9; i++) idle(10'b0000100000, "R6 source 5");
    wctl(1, 2);
    for (int i = 0; i < 6; i++) idle(10'b0000000100, "R9 source 2");

    wctl(0, 2);
    drain();
    check("R1 busy after disable", int'(busy), 0);
    for (int i = 0; i < 6; i++) idle('1, "R2 disabled");
    drain();
    drain();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule